// File: doc/BRIEF.md
# Burst Frame Generator with Byte-Sum Checksum

This block sits behind the word-level side of a serial peripheral slave and answers a burst request. When the slave hands over a received 16-bit command equal to 0x6800 while chip select is low, the block captures every value it will send in one snapshot. It then loads one output word per following frame for the neighbouring bit serializer. The host keeps chip select low for the whole exchange. The serializer shifts out whichever word sits on `txWord` during the next frame.

Three mode inputs choose one of eight word orders. They select narrow (16-bit) or wide (32-bit) sample words, rate/acceleration or delta-angle/delta-velocity content, and a sample counter or a timestamp as the closing data word. The frame after the last data word carries a 16-bit checksum, formed by adding every earlier byte of the burst as an unsigned 8-bit number. After that the block sends zeros and raises a one-cycle completion pulse.

Top module: `burst_frame_gen`

## Requirements
- R1: A `wordStrobe` cycle with `csN` low, `rxWord` = 0x6800 and no burst in progress starts a burst. At the clock edge that samples that strobe, `txWord` takes the status word, ready for the next frame. Any other received word in the idle state, and any strobe with `csN` high, leave `txWord` at 0x0000.
- R2: With `wideSel`=0 and `deltaSel`=0, each later strobe loads the next word in this order: status, rate X, Y, Z, acceleration X, Y, Z, temperature, closing word, then checksum. In each packed bus, axis X occupies bits [15:0], Y [31:16] and Z [47:32].
- R3: With `deltaSel`=1, the delta-angle X/Y/Z words take the places of the rate words and the delta-velocity X/Y/Z words take the places of the acceleration words.
- R4: With `wideSel`=1, each of the six axis channels sends its low word (`*Lo` bus) immediately before its high word (`*Hi` bus). Status still leads, and temperature and the closing word still follow the axis words.
- R5: The closing word is `countIn` when `stampSel`=0 and `stampIn` when `stampSel`=1.
- R6: The checksum word equals the sum, truncated to 16 bits, of the upper and lower bytes of every earlier output word of the burst, each byte taken as unsigned.
- R7: A narrow burst spans 11 frames and a wide burst 17, counting the command frame. The strobe that ends the checksum frame loads 0x0000 and makes `burstDone` high for exactly the following cycle. Later strobes in the same chip-select window keep 0x0000 and raise no further pulse.
- R8: All sent values and all three mode inputs are sampled at the clock edge that takes the command. Changes on them during the burst have no effect on that burst.
- R9: `csN` high at a clock edge ends any burst. `txWord` becomes 0x0000 and no `burstDone` pulse follows. A new command is accepted after `csN` falls again.
- R10: While `rstN` is low, `txWord` is 0x0000 and `burstDone` is 0.
- R11: Between strobes, with `csN` low, `txWord` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| wordStrobe | input | 1 | One-cycle pulse when a received word is complete |
| rxWord | input | 16 | Word just received from the host |
| wideSel | input | 1 | 1 selects 32-bit sample words |
| deltaSel | input | 1 | 1 selects delta-angle/delta-velocity content |
| stampSel | input | 1 | 1 selects the timestamp as closing word |
| statusIn | input | 16 | Status word |
| rateHi | input | 48 | Rate high words, X/Y/Z |
| rateLo | input | 48 | Rate low words, X/Y/Z |
| accHi | input | 48 | Acceleration high words, X/Y/Z |
| accLo | input | 48 | Acceleration low words, X/Y/Z |
| angHi | input | 48 | Delta-angle high words, X/Y/Z |
| angLo | input | 48 | Delta-angle low words, X/Y/Z |
| velHi | input | 48 | Delta-velocity high words, X/Y/Z |
| velLo | input | 48 | Delta-velocity low words, X/Y/Z |
| tempIn | input | 16 | Temperature word |
| countIn | input | 16 | Sample counter word |
| stampIn | input | 16 | Timestamp word |
| txWord | output | 16 | Word for the serializer to send in the next frame |
| burstDone | output | 1 | One-cycle pulse after the checksum frame |

## Verification
All eight mode combinations are driven, each with three data patterns. The first pattern puts a different value in every word, so a word sent in the wrong position is caught. The second is all-ones, which gives the largest checksum. The third is all-zeros, which shows that nothing stale carries over from an earlier burst. In every burst the data and mode inputs are changed right after the command, so a missing snapshot shows up as a wrong word. Separate runs cover an aborted burst, a non-burst command, a command sent with chip select high and extra frames after the checksum, which separate correct start, abort and tail handling from loose ones.

// File: rtl/burst_frame_pkg.sv
package burst_frame_pkg;

  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_SUM,
    ST_TAIL
  } burst_state_e;

  typedef struct packed {
    logic             takeSnap;
    logic             loadData;
    logic             loadSum;
    logic             loadZero;
    logic             wide;
    logic [IDX_W-1:0] idx;
  } burst_ctrl_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_frame_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AXES = 3,
  parameter logic [WORD_W-1:0] CMD = 16'h6800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wordStrobe,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              wideSel,
  output burst_ctrl_t       ctrl,
  output logic              burstDone
);

  localparam int CHANS = 2 * AXES;
  localparam int NARROW_CNT = 3 + CHANS;
  localparam int WIDE_CNT = 3 + 2 * CHANS;

  burst_state_e     state;
  logic [IDX_W-1:0] idx;
  logic             wideQ;
  logic             doneQ;
  logic [IDX_W-1:0] dataCnt;
  logic             live;

  assign dataCnt = wideQ ? IDX_W'(WIDE_CNT) : IDX_W'(NARROW_CNT);
  assign live = !csN && wordStrobe;

  always_comb begin
    ctrl.takeSnap = live && (state == ST_IDLE) && (rxWord == CMD);
    ctrl.loadData = live && (state == ST_DATA) && (idx != dataCnt);
    ctrl.loadSum  = live && (state == ST_DATA) && (idx == dataCnt);
    ctrl.loadZero = csN || (live && (state == ST_SUM));
    ctrl.wide     = wideQ;
    ctrl.idx      = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      wideQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (csN) begin
        state <= ST_IDLE;
        idx   <= '0;
      end else if (wordStrobe) begin
        case (state)
          ST_IDLE: if (rxWord == CMD) begin
            state <= ST_DATA;
            idx   <= IDX_W'(1);
            wideQ <= wideSel;
          end
          ST_DATA: begin
            if (idx == dataCnt) state <= ST_SUM;
            else idx <= idx + 1'b1;
          end
          ST_SUM: begin
            state <= ST_TAIL;
            doneQ <= 1'b1;
          end
          default: state <= ST_TAIL;
        endcase
      end
    end
  end

  assign burstDone = doneQ;

endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_frame_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AXES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  burst_ctrl_t            ctrl,
  input  logic                   deltaSel,
  input  logic                   stampSel,
  input  logic [WORD_W-1:0]      statusIn,
  input  logic [AXES*WORD_W-1:0] rateHi,
  input  logic [AXES*WORD_W-1:0] rateLo,
  input  logic [AXES*WORD_W-1:0] accHi,
  input  logic [AXES*WORD_W-1:0] accLo,
  input  logic [AXES*WORD_W-1:0] angHi,
  input  logic [AXES*WORD_W-1:0] angLo,
  input  logic [AXES*WORD_W-1:0] velHi,
  input  logic [AXES*WORD_W-1:0] velLo,
  input  logic [WORD_W-1:0]      tempIn,
  input  logic [WORD_W-1:0]      countIn,
  input  logic [WORD_W-1:0]      stampIn,
  output logic [WORD_W-1:0]      txWord
);

  localparam int CHANS = 2 * AXES;
  localparam int BYTES = WORD_W / 8;

  logic [WORD_W-1:0] liveHi [CHANS];
  logic [WORD_W-1:0] liveLo [CHANS];
  logic [WORD_W-1:0] snapHi [CHANS];
  logic [WORD_W-1:0] snapLo [CHANS];
  logic [WORD_W-1:0] snapTemp;
  logic [WORD_W-1:0] snapTail;
  logic [WORD_W-1:0] csum;
  logic [WORD_W-1:0] pick;

  function automatic logic [WORD_W-1:0] byteSum(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] s;
    s = '0;
    for (int b = 0; b < BYTES; b++) s = s + WORD_W'(w[b*8 +: 8]);
    return s;
  endfunction

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    if (c < AXES) begin : g_first
      assign liveHi[c] = deltaSel ? angHi[c*WORD_W +: WORD_W] : rateHi[c*WORD_W +: WORD_W];
      assign liveLo[c] = deltaSel ? angLo[c*WORD_W +: WORD_W] : rateLo[c*WORD_W +: WORD_W];
    end else begin : g_second
      assign liveHi[c] = deltaSel ? velHi[(c-AXES)*WORD_W +: WORD_W]
                                  : accHi[(c-AXES)*WORD_W +: WORD_W];
      assign liveLo[c] = deltaSel ? velLo[(c-AXES)*WORD_W +: WORD_W]
                                  : accLo[(c-AXES)*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    logic [IDX_W-1:0] off;
    int               chan;
    off  = ctrl.idx - 1'b1;
    chan = 0;
    pick = '0;
    if (!ctrl.wide) begin
      if (ctrl.idx >= IDX_W'(1) && ctrl.idx <= IDX_W'(CHANS)) pick = snapHi[int'(off)];
      else if (ctrl.idx == IDX_W'(CHANS + 1)) pick = snapTemp;
      else if (ctrl.idx == IDX_W'(CHANS + 2)) pick = snapTail;
    end else begin
      chan = int'(off >> 1);
      if (ctrl.idx >= IDX_W'(1) && ctrl.idx <= IDX_W'(2 * CHANS))
        pick = off[0] ? snapHi[chan] : snapLo[chan];
      else if (ctrl.idx == IDX_W'(2 * CHANS + 1)) pick = snapTemp;
      else if (ctrl.idx == IDX_W'(2 * CHANS + 2)) pick = snapTail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord   <= '0;
      csum     <= '0;
      snapTemp <= '0;
      snapTail <= '0;
      for (int c = 0; c < CHANS; c++) begin
        snapHi[c] <= '0;
        snapLo[c] <= '0;
      end
    end else if (ctrl.takeSnap) begin
      for (int c = 0; c < CHANS; c++) begin
        snapHi[c] <= liveHi[c];
        snapLo[c] <= liveLo[c];
      end
      snapTemp <= tempIn;
      snapTail <= stampSel ? stampIn : countIn;
      txWord   <= statusIn;
      csum     <= byteSum(statusIn);
    end else if (ctrl.loadData) begin
      txWord <= pick;
      csum   <= csum + byteSum(pick);
    end else if (ctrl.loadSum) begin
      txWord <= csum;
    end else if (ctrl.loadZero) begin
      txWord <= '0;
    end
  end

endmodule

// File: rtl/burst_frame_gen.sv
module burst_frame_gen
  import burst_frame_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AXES = 3,
  parameter logic [WORD_W-1:0] CMD = 16'h6800
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   wordStrobe,
  input  logic [WORD_W-1:0]      rxWord,
  input  logic                   wideSel,
  input  logic                   deltaSel,
  input  logic                   stampSel,
  input  logic [WORD_W-1:0]      statusIn,
  input  logic [AXES*WORD_W-1:0] rateHi,
  input  logic [AXES*WORD_W-1:0] rateLo,
  input  logic [AXES*WORD_W-1:0] accHi,
  input  logic [AXES*WORD_W-1:0] accLo,
  input  logic [AXES*WORD_W-1:0] angHi,
  input  logic [AXES*WORD_W-1:0] angLo,
  input  logic [AXES*WORD_W-1:0] velHi,
  input  logic [AXES*WORD_W-1:0] velLo,
  input  logic [WORD_W-1:0]      tempIn,
  input  logic [WORD_W-1:0]      countIn,
  input  logic [WORD_W-1:0]      stampIn,
  output logic [WORD_W-1:0]      txWord,
  output logic                   burstDone
);

  burst_ctrl_t ctrl;

  burst_ctrl #(.WORD_W(WORD_W), .AXES(AXES), .CMD(CMD)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wordStrobe(wordStrobe),
    .rxWord(rxWord), .wideSel(wideSel), .ctrl(ctrl), .burstDone(burstDone)
  );

  burst_dp #(.WORD_W(WORD_W), .AXES(AXES)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .deltaSel(deltaSel), .stampSel(stampSel),
    .statusIn(statusIn), .rateHi(rateHi), .rateLo(rateLo), .accHi(accHi),
    .accLo(accLo), .angHi(angHi), .angLo(angLo), .velHi(velHi), .velLo(velLo),
    .tempIn(tempIn), .countIn(countIn), .stampIn(stampIn), .txWord(txWord)
  );

endmodule

// File: rtl/burst_frame_chk.sv
module burst_frame_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              wordStrobe,
  input logic [WORD_W-1:0] txWord,
  input logic              burstDone
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone); // R7

  AST_DONE_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> $past(wordStrobe)); // R7

  AST_CS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (txWord == '0)); // R9

  AST_NO_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> !$past(csN)); // R9

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !wordStrobe) |=> $stable(txWord)); // R11

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!burstDone); // R10
    end
  end

endmodule

bind burst_frame_gen burst_frame_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wordStrobe(wordStrobe),
  .txWord(txWord), .burstDone(burstDone)
);

// File: tb/burst_frame_gen_bench.sv
module burst_frame_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        wordStrobe = 1'b0;
  logic [15:0] rxWord = '0;
  logic        wideSel = 1'b0, deltaSel = 1'b0, stampSel = 1'b0;
  logic [15:0] statusIn, tempIn, countIn, stampIn;
  logic [47:0] rateHi, rateLo, accHi, accLo, angHi, angLo, velHi, velLo;
  logic [15:0] txWord;
  logic        burstDone;

  int checks = 0;
  int fails = 0;
  logic [15:0] expW [20];
  int          nExp;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_frame_gen u_burst_frame_gen (
    .clk(clk), .rstN(rstN), .csN(csN), .wordStrobe(wordStrobe), .rxWord(rxWord),
    .wideSel(wideSel), .deltaSel(deltaSel), .stampSel(stampSel),
    .statusIn(statusIn), .rateHi(rateHi), .rateLo(rateLo), .accHi(accHi),
    .accLo(accLo), .angHi(angHi), .angLo(angLo), .velHi(velHi), .velLo(velLo),
    .tempIn(tempIn), .countIn(countIn), .stampIn(stampIn),
    .txWord(txWord), .burstDone(burstDone)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] patWord(input int pat, input int k);
    if (pat == 1) return 16'hFFFF;
    if (pat == 2) return 16'h0000;
    return 16'((pat + 3) * 4099 + k * 2731) ^ 16'(k << 11);
  endfunction

  task automatic setInputs(input int pat);
    statusIn = patWord(pat, 0);
    tempIn   = patWord(pat, 1);
    countIn  = patWord(pat, 2);
    stampIn  = patWord(pat, 3);
    for (int a = 0; a < 3; a++) begin
      rateHi[a*16 +: 16] = patWord(pat, 4 + a);
      rateLo[a*16 +: 16] = patWord(pat, 7 + a);
      accHi[a*16 +: 16]  = patWord(pat, 10 + a);
      accLo[a*16 +: 16]  = patWord(pat, 13 + a);
      angHi[a*16 +: 16]  = patWord(pat, 16 + a);
      angLo[a*16 +: 16]  = patWord(pat, 19 + a);
      velHi[a*16 +: 16]  = patWord(pat, 22 + a);
      velLo[a*16 +: 16]  = patWord(pat, 25 + a);
    end
  endtask

  task automatic buildExp(input logic w, input logic d, input logic s);
    logic [15:0] hi, lo;
    nExp = 0;
    expW[nExp++] = statusIn;
    for (int c = 0; c < 6; c++) begin
      if (c < 3) begin
        hi = d ? angHi[c*16 +: 16] : rateHi[c*16 +: 16];
        lo = d ? angLo[c*16 +: 16] : rateLo[c*16 +: 16];
      end else begin
        hi = d ? velHi[(c-3)*16 +: 16] : accHi[(c-3)*16 +: 16];
        lo = d ? velLo[(c-3)*16 +: 16] : accLo[(c-3)*16 +: 16];
      end
      if (w) expW[nExp++] = lo;
      expW[nExp++] = hi;
    end
    expW[nExp++] = tempIn;
    expW[nExp++] = s ? stampIn : countIn;
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    wordStrobe = 1'b1;
    rxWord = w;
    @(negedge clk);
    wordStrobe = 1'b0;
  endtask

  task automatic fullBurst(input int mode, input int pat);
    logic        w, d, s;
    logic [15:0] sum;
    string       req;
    w = mode[2]; d = mode[1]; s = mode[0];
    req = w ? "R4" : (d ? "R3" : "R2");
    setInputs(pat);
    wideSel = w; deltaSel = d; stampSel = s;
    buildExp(w, d, s);
    @(negedge clk);
    csN = 1'b0;
    sendWord(16'h6800);
    check("R1 status after command", txWord, expW[0]);
    // R8: disturb inputs and modes right after the command
    setInputs(pat + 5);
    wideSel = ~w; deltaSel = ~d; stampSel = ~s;
    sum = '0;
    sum = sum + 16'(expW[0][15:8]) + 16'(expW[0][7:0]);
    for (int k = 1; k < nExp; k++) begin
      sendWord(16'h0000);
      if (k == nExp - 1) check(s ? "R5 timestamp tail" : "R5 counter tail", txWord, expW[k]);
      else check({req, " R8 word order"}, txWord, expW[k]);
      sum = sum + 16'(expW[k][15:8]) + 16'(expW[k][7:0]);
    end
    sendWord(16'h0000);
    check("R6 checksum", txWord, sum);
    check("R7 no early done", {15'd0, burstDone}, 16'd0);
    sendWord(16'h0000);
    check("R7 zero after checksum", txWord, 16'h0000);
    check("R7 done pulse", {15'd0, burstDone}, 16'd1);
    check("R7 frame count", 16'(nExp + 2), w ? 16'd17 : 16'd11);
    sendWord(16'h6800);
    check("R7 tail stays zero", txWord, 16'h0000);
    check("R7 single done", {15'd0, burstDone}, 16'd0);
    @(negedge clk);
    csN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    setInputs(0);
    repeat (3) @(negedge clk);
    check("R10 reset txWord", txWord, 16'h0000);
    check("R10 reset done", {15'd0, burstDone}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int pat = 0; pat < 3; pat++)
      for (int mode = 0; mode < 8; mode++)
        fullBurst(mode, pat);

    // R1: command with chip select high is ignored
    setInputs(0);
    sendWord(16'h6800);
    check("R1 cs high ignored", txWord, 16'h0000);

    // R1: a non-burst command leaves output at zero
    @(negedge clk);
    csN = 1'b0;
    sendWord(16'h7200);
    check("R1 other command ignored", txWord, 16'h0000);
    @(negedge clk);
    check("R11 hold between strobes", txWord, 16'h0000);
    @(negedge clk);
    csN = 1'b1;
    @(negedge clk);

    // R9: abort in the middle of a burst, then restart
    setInputs(0);
    wideSel = 1'b0; deltaSel = 1'b0; stampSel = 1'b0;
    buildExp(1'b0, 1'b0, 1'b0);
    csN = 1'b0;
    sendWord(16'h6800);
    sendWord(16'h0000);
    sendWord(16'h0000);
    check("R9 mid-burst word", txWord, expW[2]);
    csN = 1'b1;
    @(negedge clk);
    check("R9 abort clears output", txWord, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 no done after abort", {15'd0, burstDone}, 16'd0);
    end
    fullBurst(5, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule